// File: doc/BRIEF.md
# 4B/5B Receive Symbol Decoder with Delimiter Validation

The block turns a stream of 5-bit code groups, one per clock and already aligned to symbol boundaries, into a nibble-wide receive interface: a data nibble, a data-valid flag, an error flag and a carrier-sense flag. A frame opens with a two-symbol start delimiter, and both of its symbols are delivered as preamble nibbles. It closes with a two-symbol end delimiter. Between the two, data code groups are translated back to their 4-bit values.

The decoder tracks where it is in the stream. Each half of a delimiter is accepted only where it belongs, and anything out of place or not a legal code is reported on the error flag. Every symbol is held for one extra clock so that the symbol after it can be seen before the decision is made. This lets a delimiter pair be confirmed before either of its nibbles leaves the block.

After an error the decoder waits for a run of idle symbols before it will accept a new frame. A bypass input skips decoding altogether and passes the raw 5-bit symbol out.

Top module: `rx45_decoder`

## Requirements
- R1: After reset, and while idle symbols (11111) arrive outside a frame, rxd_o is 0 and rx_dv_o, rx_er_o and crs_o are all low.
- R2: The outputs for a symbol are registered. They appear after the second rising clock edge following the cycle in which that symbol is applied to sym_i.
- R3: Inside a frame, data code groups decode to nibbles with rx_dv_o and crs_o high. The mapping is: 0:11110, 1:01001, 2:10100, 3:10101, 4:01010, 5:01011, 6:01110, 7:01111, 8:10010, 9:10011, A:10110, B:10111, C:11010, D:11011, E:11100, F:11101.
- R4: Outside a frame, 11000 immediately followed by 10001 starts a frame. Both symbols are output as nibble 0101 with rx_dv_o and crs_o high and rx_er_o low. rx_dv_o rises only at such a start.
- R5: Inside a frame, any code that is neither data nor a delimiter raises rx_er_o for that symbol, with rxd_o at 0 and rx_dv_o and crs_o still high, and the frame is aborted. This covers 00000, 00001, 00010, 00011, 00101, 00110, 01000, 01100, 10000, 11001, the halt code 00100, and idle 11111.
- R6: Inside a frame, 01101 immediately followed by 00111 ends the frame. Both symbols are output with rx_dv_o, crs_o and rx_er_o low, and the decoder returns to idle.
- R7: A delimiter half out of context raises rx_er_o. This covers 11000 not followed by 10001, 10001 not directly after an accepted 11000, 01101 not followed by 00111, and 00111 not directly after an accepted 01101. Outside a frame, any non-idle symbol that does not begin a valid start pair also raises rx_er_o, with rx_dv_o and crs_o low.
- R8: After any error, rx_dv_o and crs_o stay low and every non-idle symbol raises rx_er_o. A new frame is accepted only after IDLE_EXIT consecutive idle symbols (default 2); a non-idle symbol restarts that count.
- R9: While bypass_i is high, rxd_o carries symbol bits [3:0] and rx_er_o carries bit 4, with the same latency as R2. rx_dv_o and crs_o are low, no delimiter checking is done, and the decoder is returned to its idle state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sym_i | input | 5 | Aligned code group, one per clock |
| bypass_i | input | 1 | Raw pass-through of the 5-bit symbol |
| rxd_o | output | 4 | Decoded nibble, or raw bits [3:0] in bypass |
| rx_dv_o | output | 1 | Receive data valid |
| rx_er_o | output | 1 | Receive error, or raw bit 4 in bypass |
| crs_o | output | 1 | Carrier sense |

## Verification
A wrong stream state shows at the ports within two edges of the symbol that exposes it. A decoder that thinks it is inside a frame turns the next idle into an error while keeping rx_dv_o high. A decoder that thinks it is outside a frame flags the next data symbol with rx_dv_o low. A miscounted idle run in recovery shows as a start delimiter that is accepted too early, or rejected too late, on the first such pair. A slip in the one-symbol lookahead moves every nibble by a cycle, which the reference model catches on the first frame.

// File: rtl/rx45_pkg.sv
package rx45_pkg;
  localparam int SYM_W = 5;
  localparam int NIB_W = 4;

  localparam logic [SYM_W-1:0] C_IDLE = 5'b11111;
  localparam logic [SYM_W-1:0] C_SSD1 = 5'b11000;
  localparam logic [SYM_W-1:0] C_SSD2 = 5'b10001;
  localparam logic [SYM_W-1:0] C_ESD1 = 5'b01101;
  localparam logic [SYM_W-1:0] C_ESD2 = 5'b00111;
  localparam logic [NIB_W-1:0] PRE_NIB = 4'b0101;

  typedef enum logic [2:0] {
    K_DATA, K_IDLE, K_SSD1, K_SSD2, K_ESD1, K_ESD2, K_BAD
  } sym_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SSD, ST_BODY, ST_ESD, ST_RECOVER
  } rx_state_e;

  typedef struct packed {
    logic [NIB_W-1:0] nib;
    logic             dv;
    logic             er;
    logic             crs;
  } rx_out_t;

  // {hit, nibble} for data code groups
  function automatic logic [NIB_W:0] nib_of_sym(input logic [SYM_W-1:0] s);
    case (s)
      5'b11110: return {1'b1, 4'h0};
      5'b01001: return {1'b1, 4'h1};
      5'b10100: return {1'b1, 4'h2};
      5'b10101: return {1'b1, 4'h3};
      5'b01010: return {1'b1, 4'h4};
      5'b01011: return {1'b1, 4'h5};
      5'b01110: return {1'b1, 4'h6};
      5'b01111: return {1'b1, 4'h7};
      5'b10010: return {1'b1, 4'h8};
      5'b10011: return {1'b1, 4'h9};
      5'b10110: return {1'b1, 4'hA};
      5'b10111: return {1'b1, 4'hB};
      5'b11010: return {1'b1, 4'hC};
      5'b11011: return {1'b1, 4'hD};
      5'b11100: return {1'b1, 4'hE};
      5'b11101: return {1'b1, 4'hF};
      default:  return '0;
    endcase
  endfunction

  function automatic sym_kind_e kind_of_sym(input logic [SYM_W-1:0] s);
    logic [NIB_W:0] hit;
    hit = nib_of_sym(s);
    if (hit[NIB_W]) return K_DATA;
    case (s)
      C_IDLE:  return K_IDLE;
      C_SSD1:  return K_SSD1;
      C_SSD2:  return K_SSD2;
      C_ESD1:  return K_ESD1;
      C_ESD2:  return K_ESD2;
      default: return K_BAD;
    endcase
  endfunction
endpackage

// File: rtl/rx45_classify.sv
module rx45_classify
  import rx45_pkg::*;
(
  input  logic [SYM_W-1:0] sym,
  output sym_kind_e        kind
);
  assign kind = kind_of_sym(sym);
endmodule

// File: rtl/rx45_fsm.sv
module rx45_fsm
  import rx45_pkg::*;
#(
  parameter int IDLE_EXIT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bypass_i,
  input  logic [SYM_W-1:0] cur_sym,
  input  sym_kind_e        cur_kind,
  input  sym_kind_e        nxt_kind,
  output rx_out_t          out_d,
  output rx_state_e        st_o,
  output logic             ev_start,
  output logic             ev_end,
  output logic             ev_err
);
  localparam int CW = (IDLE_EXIT > 1) ? $clog2(IDLE_EXIT) : 1;
  localparam logic [CW-1:0] RUN_LAST = CW'(IDLE_EXIT - 1);

  rx_state_e      st_q, st_d;
  logic [CW-1:0]  run_q, run_d;
  logic           err_raw, start_raw, end_raw;
  logic [NIB_W:0] data_hit;

  assign data_hit = nib_of_sym(cur_sym);

  always_comb begin
    st_d      = st_q;
    run_d     = run_q;
    out_d     = '0;
    err_raw   = 1'b0;
    start_raw = 1'b0;
    end_raw   = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (cur_kind == K_SSD1 && nxt_kind == K_SSD2) begin
          out_d.nib = PRE_NIB;
          out_d.dv  = 1'b1;
          out_d.crs = 1'b1;
          st_d      = ST_SSD;
          start_raw = 1'b1;
        end else if (cur_kind != K_IDLE) begin
          err_raw = 1'b1;
        end
      end
      ST_SSD: begin
        out_d.dv  = 1'b1;
        out_d.crs = 1'b1;
        if (cur_kind == K_SSD2) begin
          out_d.nib = PRE_NIB;
          st_d      = ST_BODY;
        end else begin
          err_raw = 1'b1;
        end
      end
      ST_BODY: begin
        out_d.dv  = 1'b1;
        out_d.crs = 1'b1;
        if (cur_kind == K_DATA) begin
          out_d.nib = data_hit[NIB_W-1:0];
        end else if (cur_kind == K_ESD1 && nxt_kind == K_ESD2) begin
          out_d.dv  = 1'b0;
          out_d.crs = 1'b0;
          st_d      = ST_ESD;
          end_raw   = 1'b1;
        end else begin
          err_raw = 1'b1;
        end
      end
      ST_ESD: begin
        if (cur_kind == K_ESD2) st_d = ST_IDLE;
        else                    err_raw = 1'b1;
      end
      ST_RECOVER: begin
        if (cur_kind == K_IDLE) begin
          if (run_q == RUN_LAST) begin
            st_d  = ST_IDLE;
            run_d = '0;
          end else begin
            run_d = run_q + 1'b1;
          end
        end else begin
          err_raw = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
    if (err_raw) begin
      out_d.er  = 1'b1;
      out_d.nib = '0;
      st_d      = ST_RECOVER;
      run_d     = '0;
    end
    if (bypass_i) begin
      st_d  = ST_IDLE;
      run_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      run_q <= '0;
    end else begin
      st_q  <= st_d;
      run_q <= run_d;
    end
  end

  assign st_o     = st_q;
  assign ev_err   = err_raw   & ~bypass_i;
  assign ev_start = start_raw & ~bypass_i;
  assign ev_end   = end_raw   & ~bypass_i;
endmodule

// File: rtl/rx45_outreg.sv
module rx45_outreg
  import rx45_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bypass_i,
  input  logic [SYM_W-1:0] raw_sym,
  input  rx_out_t          dec_d,
  output logic [NIB_W-1:0] rxd_o,
  output logic             rx_dv_o,
  output logic             rx_er_o,
  output logic             crs_o
);
  rx_out_t nxt_out, out_q;

  always_comb begin
    nxt_out = dec_d;
    if (bypass_i) begin
      nxt_out.nib = raw_sym[NIB_W-1:0];
      nxt_out.er  = raw_sym[SYM_W-1];
      nxt_out.dv  = 1'b0;
      nxt_out.crs = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= '0;
    else        out_q <= nxt_out;
  end

  assign rxd_o   = out_q.nib;
  assign rx_dv_o = out_q.dv;
  assign rx_er_o = out_q.er;
  assign crs_o   = out_q.crs;
endmodule

// File: rtl/rx45_decoder.sv
module rx45_decoder
  import rx45_pkg::*;
#(
  parameter int IDLE_EXIT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SYM_W-1:0] sym_i,
  input  logic             bypass_i,
  output logic [NIB_W-1:0] rxd_o,
  output logic             rx_dv_o,
  output logic             rx_er_o,
  output logic             crs_o
);
  localparam int LOOK = 2;  // [0] held symbol, [1] lookahead

  logic [SYM_W-1:0] sym_q;
  logic [SYM_W-1:0] cls_in [LOOK];
  sym_kind_e        kind_w [LOOK];
  rx_out_t          dec_d;
  rx_state_e        st;
  logic             ev_start, ev_end, ev_err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sym_q <= C_IDLE;
    else        sym_q <= sym_i;
  end

  assign cls_in[0] = sym_q;
  assign cls_in[1] = sym_i;

  for (genvar g = 0; g < LOOK; g++) begin : g_cls
    rx45_classify u_cls (.sym(cls_in[g]), .kind(kind_w[g]));
  end

  rx45_fsm #(.IDLE_EXIT(IDLE_EXIT)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .bypass_i (bypass_i),
    .cur_sym  (sym_q),
    .cur_kind (kind_w[0]),
    .nxt_kind (kind_w[1]),
    .out_d    (dec_d),
    .st_o     (st),
    .ev_start (ev_start),
    .ev_end   (ev_end),
    .ev_err   (ev_err)
  );

  rx45_outreg u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .bypass_i (bypass_i),
    .raw_sym  (sym_q),
    .dec_d    (dec_d),
    .rxd_o    (rxd_o),
    .rx_dv_o  (rx_dv_o),
    .rx_er_o  (rx_er_o),
    .crs_o    (crs_o)
  );
endmodule

// File: rtl/rx45_decoder_chk.sv
module rx45_decoder_chk
  import rx45_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             bypass_i,
  input logic [NIB_W-1:0] rxd_o,
  input logic             rx_dv_o,
  input logic             rx_er_o,
  input logic             crs_o,
  input logic             ev_start,
  input logic             ev_end,
  input logic             ev_err,
  input rx_state_e        st
);
  a_r4_dv_needs_crs: assert property (@(posedge clk) disable iff (!rst_n)
    rx_dv_o |-> crs_o);

  a_r4_start_emits_preamble: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |=> (rx_dv_o && crs_o && !rx_er_o && rxd_o == PRE_NIB));

  a_r4_dv_rises_on_preamble: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_dv_o) |-> (rxd_o == PRE_NIB && !rx_er_o));

  a_r5_error_reported: assert property (@(posedge clk) disable iff (!rst_n)
    ev_err |=> rx_er_o);

  a_r6_end_drops_carrier: assert property (@(posedge clk) disable iff (!rst_n)
    ev_end |=> (!crs_o && !rx_dv_o && !rx_er_o));

  a_r8_recover_no_dv: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RECOVER) |=> (!rx_dv_o && !crs_o));

  a_r9_bypass_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    bypass_i |=> (!rx_dv_o && !crs_o));
endmodule

bind rx45_decoder rx45_decoder_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bypass_i (bypass_i),
  .rxd_o    (rxd_o),
  .rx_dv_o  (rx_dv_o),
  .rx_er_o  (rx_er_o),
  .crs_o    (crs_o),
  .ev_start (ev_start),
  .ev_end   (ev_end),
  .ev_err   (ev_err),
  .st       (st)
);

// File: tb/tb_rx45_decoder.sv
`timescale 1ns/1ps
module tb_rx45_decoder;
  localparam int EXIT_RUN = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] sym_i = 5'b11111;
  logic       bypass_i = 1'b0;
  logic [3:0] rxd_o;
  logic       rx_dv_o, rx_er_o, crs_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rx45_decoder #(.IDLE_EXIT(EXIT_RUN)) dut (
    .clk(clk), .rst_n(rst_n), .sym_i(sym_i), .bypass_i(bypass_i),
    .rxd_o(rxd_o), .rx_dv_o(rx_dv_o), .rx_er_o(rx_er_o), .crs_o(crs_o));

  // data code for nibble n is dcode[n]
  logic [4:0] dcode [16] = '{5'b11110, 5'b01001, 5'b10100, 5'b10101,
                             5'b01010, 5'b01011, 5'b01110, 5'b01111,
                             5'b10010, 5'b10011, 5'b10110, 5'b10111,
                             5'b11010, 5'b11011, 5'b11100, 5'b11101};
  logic [4:0] badcode [11] = '{5'b00000, 5'b00001, 5'b00010, 5'b00011,
                               5'b00101, 5'b00110, 5'b01000, 5'b01100,
                               5'b10000, 5'b11001, 5'b00100};

  // 0 data, 1 idle, 2 J, 3 K, 4 T, 5 R, 6 bad
  function automatic int sym_class(input logic [4:0] s);
    for (int i = 0; i < 16; i++) if (dcode[i] == s) return 0;
    if (s == 5'b11111) return 1;
    if (s == 5'b11000) return 2;
    if (s == 5'b10001) return 3;
    if (s == 5'b01101) return 4;
    if (s == 5'b00111) return 5;
    return 6;
  endfunction

  function automatic logic [3:0] sym_value(input logic [4:0] s);
    for (int i = 0; i < 16; i++) if (dcode[i] == s) return 4'(i);
    return 4'h0;
  endfunction

  // reference model: 0 idle, 1 start seen, 2 body, 3 end seen, 4 recovering
  int         m_mode = 0;
  int         m_run = 0;
  logic [4:0] m_sq = 5'b11111;
  logic [3:0] e_nib;
  logic       e_dv, e_er, e_crs;
  string      e_tag;

  task automatic model_edge(input logic [4:0] nx, input logic b);
    int  k, kn;
    bit  bad;
    k = sym_class(m_sq);
    kn = sym_class(nx);
    bad = 0;
    e_nib = 4'h0; e_dv = 0; e_er = 0; e_crs = 0; e_tag = "R1";
    if (b) begin
      e_nib = m_sq[3:0]; e_er = m_sq[4]; e_tag = "R9";
      m_mode = 0; m_run = 0;
    end else begin
      case (m_mode)
        0: begin
          if (k == 2 && kn == 3) begin
            e_nib = 4'b0101; e_dv = 1; e_crs = 1; m_mode = 1; e_tag = "R4";
          end else if (k != 1) begin
            bad = 1; e_tag = "R7";
          end
        end
        1: begin
          e_dv = 1; e_crs = 1; e_tag = "R4";
          if (k == 3) begin e_nib = 4'b0101; m_mode = 2; end
          else begin bad = 1; e_tag = "R7"; end
        end
        2: begin
          e_dv = 1; e_crs = 1;
          if (k == 0) begin
            e_nib = sym_value(m_sq); e_tag = "R3";
          end else if (k == 4 && kn == 5) begin
            e_dv = 0; e_crs = 0; m_mode = 3; e_tag = "R6";
          end else begin
            bad = 1;
            e_tag = (k == 6 || k == 1) ? "R5" : "R7";
          end
        end
        3: begin
          e_tag = "R6";
          if (k == 5) m_mode = 0;
          else begin bad = 1; e_tag = "R7"; end
        end
        default: begin
          e_tag = "R8";
          if (k == 1) begin
            m_run++;
            if (m_run >= EXIT_RUN) begin m_mode = 0; m_run = 0; end
          end else bad = 1;
        end
      endcase
      if (bad) begin e_er = 1; e_nib = 4'h0; m_mode = 4; m_run = 0; end
    end
    m_sq = nx;
  endtask

  task automatic compare(input string tag);
    checks++;
    if ({rxd_o, rx_dv_o, rx_er_o, crs_o} !== {e_nib, e_dv, e_er, e_crs}) begin
      errors++;
      $display("FAIL %s: got rxd=%h dv=%b er=%b crs=%b, expected rxd=%h dv=%b er=%b crs=%b",
               tag, rxd_o, rx_dv_o, rx_er_o, crs_o, e_nib, e_dv, e_er, e_crs);
    end
  endtask

  // apply a symbol for one cycle, starting and ending at a falling edge
  task automatic step(input logic [4:0] s, input logic b = 1'b0);
    sym_i = s;
    bypass_i = b;
    @(posedge clk);
    model_edge(s, b);
    @(negedge clk);
    compare(e_tag);
  endtask

  task automatic check_bit(input string tag, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %b, expected %b", tag, got, exp);
    end
  endtask

  task automatic idles(input int n);
    for (int i = 0; i < n; i++) step(5'b11111);
  endtask

  task automatic good_frame(input int n);
    step(5'b11000); step(5'b10001);
    for (int i = 0; i < n; i++) step(dcode[$urandom_range(0, 15)]);
    step(5'b01101); step(5'b00111);
  endtask

  initial begin
    void'($urandom(32'h45B5_0C0D));
    repeat (3) @(negedge clk);
    // R1: reset state
    checks++;
    if ({rxd_o, rx_dv_o, rx_er_o, crs_o} !== 7'b0) begin
      errors++;
      $display("FAIL R1: reset outputs got %b, expected 0000000",
               {rxd_o, rx_dv_o, rx_er_o, crs_o});
    end
    rst_n = 1'b1;
    idles(3);

    // R2: latency, dv low after J applied, high one cycle later
    step(5'b11000);
    check_bit("R2 dv one cycle after J", rx_dv_o, 1'b0);
    step(5'b10001);
    check_bit("R2 dv two edges after J", rx_dv_o, 1'b1);
    // R3: every data code in order
    for (int i = 0; i < 16; i++) step(dcode[i]);
    step(5'b01101); step(5'b00111);   // R6
    idles(2);

    // R5: each invalid code inside a frame, recovery via idles
    for (int i = 0; i < 11; i++) begin
      step(5'b11000); step(5'b10001); step(dcode[i]);
      step(badcode[i]); step(dcode[3]);
      idles(2);
    end
    // R5: idle inside a frame
    step(5'b11000); step(5'b10001); step(5'b11111); idles(2);

    // R7: context errors
    step(5'b11000); step(dcode[5]); idles(2);         // J without K
    step(5'b10001); idles(2);                          // lone K
    step(5'b11000); step(5'b10001); step(dcode[1]);
    step(5'b01101); step(dcode[2]); idles(2);          // T without R
    step(5'b11000); step(5'b10001); step(5'b00111); idles(2); // R without T
    step(5'b11000); step(5'b10001); step(5'b11000); idles(2); // J inside frame
    step(dcode[9]); idles(2);                          // data outside frame

    // R8: one idle is not enough, two are
    step(5'b00000); idles(1);
    step(5'b11000); step(5'b10001);
    check_bit("R8 start rejected after one idle", rx_dv_o, 1'b0);
    idles(2);
    good_frame(3);
    check_bit("R8 frame accepted after two idles", crs_o, 1'b0);
    idles(1);

    // R9: bypass of every code
    for (int i = 0; i < 32; i++) step(5'(i), 1'b1);
    step(5'b11111, 1'b1);
    idles(2);

    // random mix
    for (int f = 0; f < 400; f++) begin
      int kind;
      idles($urandom_range(0, 3));
      kind = $urandom_range(0, 9);
      if (kind <= 5) good_frame($urandom_range(1, 12));
      else if (kind == 6) begin
        step(5'b11000); step(5'b10001);
        for (int i = 0; i < int'($urandom_range(0, 4)); i++) step(dcode[$urandom_range(0, 15)]);
        step(5'($urandom_range(0, 31)));
        step(dcode[$urandom_range(0, 15)]);
      end else if (kind == 7) begin
        for (int i = 0; i < int'($urandom_range(1, 8)); i++) step(5'($urandom_range(0, 31)));
      end else if (kind == 8) begin
        for (int i = 0; i < int'($urandom_range(1, 8)); i++) step(5'($urandom_range(0, 31)), 1'b1);
      end else begin
        step(5'b11000); step(5'b10001); step(dcode[$urandom_range(0, 15)]);
        step(5'b01101); step(5'($urandom_range(0, 31)));
      end
      idles(2);
    end

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule